// File: doc/BRIEF.md
# SIMD Lane Execution Mask Unit

This block keeps the lane-enable mask of a scalar sequencer that drives a group of vector lanes. Each mask bit enables one lane. The scalar side sends single-cycle mask operations. These are a plain move, three logic operations (XOR, OR, AND) that may or may not be written back, a clear-by-operand operation that drops lanes from a loop, and two atomic save operations. A save operation returns the current mask on the scalar destination port and replaces the mask with a combination of that mask and the operand, all in the same step. Together these operations carry out structured predication. Entering an if region saves the mask and ANDs it with a compare result. The else region restores lanes with OR-save, then selects the pending lanes with an XOR. The end of a region ORs the saved bits back in. A loop removes lanes that have broken out, using the clear-by-operand operation.

A lane-wide compare register captures per-lane compare results from the vector side. Any operation can take its operand from this register instead of from the scalar operand. Two flags, mask-empty and mask-populated, are decoded from the stored mask so that the branch logic can skip a region or repeat a loop. A width select runs the unit with either the full 64 lanes or only the low 32. In 32-lane mode the upper half is forced to zero everywhere.

Top module: `lane_mask_unit`

## Requirements
- R1: While reset is asserted and after it is released, the mask reads all ones across the active width, with upper half zero in 32-lane mode, `dst_valid` is 0 and the compare register is 0.
- R2: Code 1 (save-AND) with `op_valid` returns the old mask on `dst_data` one cycle later and sets the mask to old mask AND operand.
- R3: Code 2 (save-OR) returns the old mask on `dst_data` and sets the mask to old mask OR operand.
- R4: Codes 3 (XOR), 4 (OR) and 6 (AND) combine the mask with the operand and return the result on `dst_data`. The mask takes the result only when `op_to_mask` is 1; otherwise the mask is left unchanged.
- R5: Code 5 (clear-by-operand) produces mask AND NOT operand, so no lane set in the operand survives.
- R6: Code 0 (move) produces the operand itself, and writes it to the mask when `op_to_mask` is 1.
- R7: `mask_empty` is 1 exactly when the visible mask is all zero, `mask_live` is its complement, and both follow the mask with no added cycle.
- R8: After each committed operation, `scc` is 1 when the result is non-zero. For save operations the result is the new mask.
- R9: With `wave32` = 1, operands are cut to the low 32 bits, and `mask`, `dst_data` and the flags see only the low 32 lanes. The upper 32 bits read as zero.
- R10: `cmp_we` loads `cmp_in` into the compare register. `op_use_cmp` = 1 selects that register as the operand. A compare write in the same cycle as the operation is forwarded to the operation.
- R11: Code 7, or a cycle with `op_valid` low, changes neither the mask, `dst_data` nor `scc`, and leaves `dst_valid` at 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wave32 | input | 1 | 1 selects 32-lane mode; change only during reset |
| op_valid | input | 1 | Commits the operation on this edge |
| op_code | input | 3 | Operation code (0..7) |
| op_src | input | 64 | Scalar operand |
| op_to_mask | input | 1 | Write non-save results back into the mask |
| op_use_cmp | input | 1 | Take the operand from the compare register |
| cmp_we | input | 1 | Load the compare register |
| cmp_in | input | 64 | Per-lane compare result |
| mask | output | 64 | Current lane-enable mask |
| dst_data | output | 64 | Scalar destination value of the last operation |
| dst_valid | output | 1 | One-cycle pulse after a committed operation |
| scc | output | 1 | Result-non-zero condition of the last operation |
| mask_empty | output | 1 | Mask is all zero |
| mask_live | output | 1 | Mask has at least one lane set |

## Verification
Two functions can collide in one cycle: a compare-register load and an operation that reads the compare register. The bench provokes this by asserting `cmp_we` with a fresh pattern and a save-AND with `op_use_cmp` on the same edge. It judges the case by checking that the new mask and `scc` reflect the pattern written in that cycle, not the previously stored one. A second overlap also gets a check, the save-AND that empties the mask: there the returned old mask and the mask-empty flag must both be correct in the same cycle.

// File: rtl/lmu_pkg.sv
package lmu_pkg;

    parameter int unsigned LMU_OPW = 3;

    typedef enum logic [LMU_OPW-1:0] {
        OP_MOV      = 3'd0,
        OP_AND_SAVE = 3'd1,
        OP_OR_SAVE  = 3'd2,
        OP_XOR      = 3'd3,
        OP_OR       = 3'd4,
        OP_ANDN2    = 3'd5,
        OP_AND      = 3'd6,
        OP_RSVD     = 3'd7
    } lmu_op_e;

endpackage

// File: rtl/lmu_operand_sel.sv
module lmu_operand_sel #(
    parameter int unsigned W    = 64,
    parameter int unsigned HALF = 32
) (
    input  logic         wave32,
    input  logic [W-1:0] op_src,
    input  logic         use_cmp,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_in,
    input  logic [W-1:0] cmp_q,
    output logic [W-1:0] width_mask,
    output logic [W-1:0] src_eff
);
    logic [W-1:0] cmp_fwd;

    for (genvar g = 0; g < W; g++) begin : g_lane
        if (g < HALF) begin : g_low
            assign width_mask[g] = 1'b1;
        end else begin : g_high
            assign width_mask[g] = ~wave32;
        end
    end

    always_comb begin
        cmp_fwd = cmp_we ? cmp_in : cmp_q;
        src_eff = (use_cmp ? cmp_fwd : op_src) & width_mask;
    end
endmodule

// File: rtl/lmu_alu.sv
module lmu_alu
    import lmu_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  lmu_op_e      op,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] src,
    output logic [W-1:0] res,
    output logic         is_save,
    output logic         known
);
    always_comb begin
        res     = '0;
        is_save = 1'b0;
        known   = 1'b1;
        unique case (op)
            OP_MOV:      res = src;
            OP_AND_SAVE: begin res = cur & src; is_save = 1'b1; end
            OP_OR_SAVE:  begin res = cur | src; is_save = 1'b1; end
            OP_XOR:      res = cur ^ src;
            OP_OR:       res = cur | src;
            OP_ANDN2:    res = cur & ~src;
            OP_AND:      res = cur & src;
            default:     known = 1'b0;
        endcase
    end
endmodule

// File: rtl/lmu_zero_det.sv
module lmu_zero_det #(
    parameter int unsigned W     = 64,
    parameter int unsigned GROUP = 8
) (
    input  logic [W-1:0] vec,
    output logic         zero,
    output logic         nonzero
);
    localparam int unsigned NGRP = (W + GROUP - 1) / GROUP;

    logic [NGRP-1:0] grp_any;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int unsigned LO = g * GROUP;
        localparam int unsigned HI = ((g + 1) * GROUP > W) ? W - 1 : (g + 1) * GROUP - 1;
        assign grp_any[g] = |vec[HI:LO];
    end

    assign nonzero = |grp_any;
    assign zero    = ~nonzero;
endmodule

// File: rtl/lane_mask_unit.sv
module lane_mask_unit
    import lmu_pkg::*;
#(
    parameter int unsigned LANES  = 64,
    parameter int unsigned NARROW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wave32,
    input  logic             op_valid,
    input  logic [LMU_OPW-1:0] op_code,
    input  logic [LANES-1:0] op_src,
    input  logic             op_to_mask,
    input  logic             op_use_cmp,
    input  logic             cmp_we,
    input  logic [LANES-1:0] cmp_in,
    output logic [LANES-1:0] mask,
    output logic [LANES-1:0] dst_data,
    output logic             dst_valid,
    output logic             scc,
    output logic             mask_empty,
    output logic             mask_live
);
    typedef struct packed {
        logic [LANES-1:0] mask;
        logic [LANES-1:0] cmp;
        logic [LANES-1:0] dst;
        logic             dst_vld;
        logic             scc;
    } lmu_state_t;

    lmu_state_t       st_d, st_q;
    logic [LANES-1:0] width_mask;
    logic [LANES-1:0] src_eff;
    logic [LANES-1:0] cur_mask;
    logic [LANES-1:0] alu_res;
    logic             alu_save;
    logic             alu_known;

    lmu_operand_sel #(.W(LANES), .HALF(NARROW)) u_opsel (
        .wave32     (wave32),
        .op_src     (op_src),
        .use_cmp    (op_use_cmp),
        .cmp_we     (cmp_we),
        .cmp_in     (cmp_in),
        .cmp_q      (st_q.cmp),
        .width_mask (width_mask),
        .src_eff    (src_eff)
    );

    assign cur_mask = st_q.mask & width_mask;

    lmu_alu #(.W(LANES)) u_alu (
        .op      (lmu_op_e'(op_code)),
        .cur     (cur_mask),
        .src     (src_eff),
        .res     (alu_res),
        .is_save (alu_save),
        .known   (alu_known)
    );

    always_comb begin
        st_d         = st_q;
        st_d.dst_vld = 1'b0;
        if (cmp_we) begin
            st_d.cmp = cmp_in;
        end
        if (op_valid && alu_known) begin
            st_d.dst_vld = 1'b1;
            st_d.scc     = |alu_res;
            if (alu_save) begin
                st_d.dst  = cur_mask;
                st_d.mask = alu_res;
            end else begin
                st_d.dst = alu_res;
                if (op_to_mask) begin
                    st_d.mask = alu_res;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask    <= width_mask;
            st_q.cmp     <= '0;
            st_q.dst     <= '0;
            st_q.dst_vld <= 1'b0;
            st_q.scc     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask      = cur_mask;
    assign dst_data  = st_q.dst & width_mask;
    assign dst_valid = st_q.dst_vld;
    assign scc       = st_q.scc;

    lmu_zero_det #(.W(LANES)) u_zdet (
        .vec     (cur_mask),
        .zero    (mask_empty),
        .nonzero (mask_live)
    );
endmodule

// File: rtl/lmu_chk.sv
module lmu_chk #(
    parameter int unsigned W    = 64,
    parameter int unsigned HALF = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wave32,
    input logic         op_valid,
    input logic [2:0]   op_code,
    input logic [W-1:0] op_src,
    input logic         op_to_mask,
    input logic         op_use_cmp,
    input logic [W-1:0] mask,
    input logic [W-1:0] dst_data,
    input logic         dst_valid,
    input logic         scc,
    input logic         mask_empty,
    input logic         mask_live
);
    // R2
    save_and_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd1) |=> (dst_data == $past(mask)) && ((mask & ~$past(mask)) == '0));

    // R3
    save_or_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd2) |=> (dst_data == $past(mask)) && (($past(mask) & ~mask) == '0));

    // R5
    clear_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd5 && op_to_mask && !op_use_cmp) |=> ((mask & $past(op_src)) == '0));

    // R7
    flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({mask_empty, mask_live}));

    // R8
    scc_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_to_mask && op_code != 3'd7) |=> (scc == (mask != '0)));

    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wave32 |-> ((mask[W-1:HALF] == '0) && (dst_data[W-1:HALF] == '0)));

    // R11
    idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code == 3'd7) |=> (!dst_valid && $stable(dst_data) && $stable(scc)));
endmodule

bind lane_mask_unit lmu_chk #(.W(LANES), .HALF(NARROW)) u_lmu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wave32     (wave32),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .op_src     (op_src),
    .op_to_mask (op_to_mask),
    .op_use_cmp (op_use_cmp),
    .mask       (mask),
    .dst_data   (dst_data),
    .dst_valid  (dst_valid),
    .scc        (scc),
    .mask_empty (mask_empty),
    .mask_live  (mask_live)
);

// File: tb/lane_mask_unit_tb_top.sv
module lane_mask_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wave32 = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [63:0] op_src = '0;
    logic        op_to_mask = 1'b0;
    logic        op_use_cmp = 1'b0;
    logic        cmp_we = 1'b0;
    logic [63:0] cmp_in = '0;
    logic [63:0] mask;
    logic [63:0] dst_data;
    logic        dst_valid;
    logic        scc;
    logic        mask_empty;
    logic        mask_live;

    int n_checks = 0;
    int n_fail   = 0;

    logic [63:0] e_mask, e_cmp, e_dst;
    logic        e_scc, e_vld;

    always #2.5 clk = ~clk;

    lane_mask_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wave32(wave32), .op_valid(op_valid),
        .op_code(op_code), .op_src(op_src), .op_to_mask(op_to_mask),
        .op_use_cmp(op_use_cmp), .cmp_we(cmp_we), .cmp_in(cmp_in),
        .mask(mask), .dst_data(dst_data), .dst_valid(dst_valid), .scc(scc),
        .mask_empty(mask_empty), .mask_live(mask_live)
    );

    function automatic logic [63:0] wmask();
        return wave32 ? 64'h0000_0000_FFFF_FFFF : '1;
    endfunction

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check64({tag, " mask"}, mask, e_mask);
        check64({tag, " dst"}, dst_data, e_dst);
        check64({tag, " valid"}, {63'd0, dst_valid}, {63'd0, e_vld});
        check64({tag, " scc"}, {63'd0, scc}, {63'd0, e_scc});
        check64({tag, " R7 flags"}, {62'd0, mask_empty, mask_live},
                {62'd0, (e_mask == '0), (e_mask != '0)});
    endtask

    // Model of one committed cycle; fwd is the compare value seen by the op.
    task automatic model(logic [2:0] c, logic [63:0] s, logic tm, logic uc, logic [63:0] fwd);
        logic [63:0] o, r, m;
        m = e_mask;
        o = (uc ? fwd : s) & wmask();
        e_vld = 1'b1;
        case (c)
            3'd0: r = o;
            3'd1: r = m & o;
            3'd2: r = m | o;
            3'd3: r = m ^ o;
            3'd4: r = m | o;
            3'd5: r = m & ~o;
            3'd6: r = m & o;
            default: begin r = '0; e_vld = 1'b0; end
        endcase
        if (e_vld) begin
            e_scc = (r != '0);
            if (c == 3'd1 || c == 3'd2) begin
                e_dst = m; e_mask = r;
            end else begin
                e_dst = r;
                if (tm) e_mask = r;
            end
        end
    endtask

    task automatic do_op(logic [2:0] c, logic [63:0] s, logic tm, logic uc);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; op_src = s; op_to_mask = tm; op_use_cmp = uc;
        model(c, s, tm, uc, e_cmp);
        @(negedge clk);
        op_valid = 1'b0; op_src = '0; op_to_mask = 1'b0; op_use_cmp = 1'b0;
    endtask

    task automatic load_cmp(logic [63:0] v);
        @(negedge clk);
        cmp_we = 1'b1; cmp_in = v;
        @(negedge clk);
        cmp_we = 1'b0;
        e_cmp = v;
    endtask

    task automatic do_reset(logic w32);
        @(negedge clk);
        rst_n = 1'b0; wave32 = w32;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        e_mask = wmask(); e_cmp = '0; e_dst = '0; e_scc = 1'b0; e_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        check_all("R1 reset64");
    endtask

    task automatic t_if_else_end();
        logic [63:0] saved;
        load_cmp(64'h00FF_00FF_0F0F_F0F0);
        do_op(3'd1, '0, 1'b0, 1'b1);          // if: save-and with compare (R10)
        check_all("R2 if save-and");
        saved = dst_data;
        do_op(3'd3, saved, 1'b0, 1'b0);       // pending lanes, scalar only
        check_all("R4 xor no-writeback");
        saved = dst_data;
        do_op(3'd2, saved, 1'b0, 1'b0);       // else: restore
        check_all("R3 else save-or");
        saved = dst_data;
        do_op(3'd3, saved, 1'b1, 1'b0);       // flip to else lanes
        check_all("R4 xor writeback");
        do_op(3'd4, saved, 1'b1, 1'b0);       // end of region
        check_all("R4 or end");
        do_op(3'd6, 64'hFFFF_0000_FFFF_0000, 1'b1, 1'b0);
        check_all("R4 and writeback");
    endtask

    task automatic t_empty_skip();
        do_op(3'd0, 64'h1234_5678_9ABC_DEF0, 1'b1, 1'b0);
        check_all("R6 move");
        do_op(3'd1, '0, 1'b0, 1'b0);
        check_all("R7 R8 empty after save-and");
        do_op(3'd2, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b0);
        check_all("R3 restore from empty");
    endtask

    task automatic t_loop();
        do_op(3'd0, 64'h0000_0000_0000_00F0, 1'b1, 1'b0);
        check_all("R6 move small");
        do_op(3'd5, 64'h0000_0000_0000_0030, 1'b1, 1'b0);
        check_all("R5 partial break");
        do_op(3'd5, 64'h0000_0000_0000_00C0, 1'b1, 1'b0);
        check_all("R5 R8 loop done");
        do_op(3'd0, 64'h0000_0000_0000_0055, 1'b0, 1'b0);
        check_all("R6 move scalar only");
    endtask

    task automatic t_idle_rsvd();
        do_op(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
        check_all("R11 reserved");
        @(negedge clk);
        op_src = 64'hAAAA; op_code = 3'd0; op_to_mask = 1'b1;
        @(negedge clk);
        op_to_mask = 1'b0;
        check_all("R11 idle");
    endtask

    task automatic t_forward();
        do_op(3'd0, '1, 1'b1, 1'b0);
        check_all("R6 all on");
        @(negedge clk);
        cmp_we = 1'b1; cmp_in = 64'h8000_0000_0000_0001;
        op_valid = 1'b1; op_code = 3'd1; op_use_cmp = 1'b1;
        model(3'd1, '0, 1'b0, 1'b1, 64'h8000_0000_0000_0001);
        e_cmp = 64'h8000_0000_0000_0001;
        @(negedge clk);
        cmp_we = 1'b0; op_valid = 1'b0; op_use_cmp = 1'b0;
        check_all("R10 same-cycle forward");
    endtask

    task automatic t_wave32();
        do_reset(1'b1);
        check_all("R1 R9 reset32");
        do_op(3'd4, 64'hFFFF_FFFF_0000_0000, 1'b1, 1'b0);
        check_all("R9 upper operand ignored");
        do_op(3'd5, 64'hFFFF_FFFF_FFFF_0000, 1'b1, 1'b0);
        check_all("R9 R5 clear low");
        do_op(3'd5, 64'h0000_0000_0000_FFFF, 1'b1, 1'b0);
        check_all("R9 R7 empty32");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        t_reset();
        t_if_else_end();
        t_empty_skip();
        t_loop();
        t_idle_rsvd();
        t_forward();
        t_wave32();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule